// File: doc/BRIEF.md
# SAR ADC Conversion and Readout Sequencer

This block is the controller-side sequencer for one successive-approximation converter connected with a separate convert line and a separate active-low select. A one-cycle start pulse raises the convert line. The select line then stays inactive for the converter's conversion time, counted in system clock cycles. After that the select goes active and the block generates a serial clock and shifts the result in, most significant bit first. Once the last bit is captured, the convert line drops. One cycle later the block presents the sample, widened to its output container, together with a one-cycle valid strobe.

Parameters set the result width and signedness, the normal and fast ("turbo") conversion times, the system clock period, the serial clock half-period in system cycles, and the serial clock polarity and phase. The conversion wait is the conversion time divided by the clock period, rounded up. A turbo input sampled at the start, or a parameter that forces turbo on, selects the shorter time.

Top module: `sar_rdout_seq`

## Requirements
- R1: After a synchronous reset, convert is low, select (cs_n_o) is high, the serial clock rests at its idle level CPOL, and busy and valid are low.
- R2: A start pulse seen while idle raises convert and busy in the next cycle. Convert then stays high for exactly N + 2*RES_W*SCLK_HALF cycles, where N is the conversion wait, and drops only after the last data bit has been captured.
- R3: While convert is high, select stays high for the first N cycles, with N = ceil(t_ns*1000/CLK_PS). Select goes low only after that and remains low for the rest of the read.
- R4: The conversion time defaults to 500 ns normal and 400 ns turbo for results wider than 16 bits, and 420 ns and 320 ns otherwise. Turbo timing is used when turbo_i is high at the start cycle, or whenever FORCE_TURBO is 1.
- R5: During a read the serial clock makes exactly 2*RES_W transitions, each SCLK_HALF system cycles apart. Whenever select is high the clock sits at CPOL.
- R6: Bits arrive most significant first. With CPHA=0 each bit is captured on a leading clock transition (away from CPOL). With CPHA=1 it is captured on a trailing transition (back to CPOL).
- R7: data_o is 16 bits wide when RES_W is 16 or less, and 32 bits otherwise. With SIGNED_RES=1 the result is sign-extended from bit RES_W-1. Otherwise it is zero-extended.
- R8: valid_o is high for exactly one cycle per conversion, in the cycle after convert falls, and data_o carries the result in that cycle.
- R9: A start pulse arriving while busy is ignored. The running result is unchanged, and no further conversion begins after it completes.
- R10: Reset asserted in the middle of a read returns the block to idle on the next cycle: convert low, select high, clock at CPOL. No valid follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle conversion request |
| turbo_i | input | 1 | Request the shorter conversion time, sampled with start |
| busy_o | output | 1 | High from the cycle after an accepted start until the result is issued |
| cnv_o | output | 1 | Convert line to the converter |
| cs_n_o | output | 1 | Active-low select to the converter's data-enable input |
| sclk_o | output | 1 | Serial clock |
| sdo_i | input | 1 | Serial data from the converter |
| data_o | output | 16 or 32 | Extended result, held until the next result |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The main function is exercised on two configurations: an 18-bit signed converter with the idle-low clock and capture on leading transitions, and a 14-bit unsigned converter with the idle-high clock, capture on trailing transitions, and forced turbo. A bench-side converter model returns words that include zero, all ones, the most negative value, the sign bit alone, and random values. These tell correct sign extension and bit order apart from shifted or reversed captures. Random turbo settings on the first configuration separate the two conversion waits, and the forced-turbo configuration shows that the parameter overrides a low turbo input. A repeated start during a read and a reset in the middle of a read check that the sequence can be neither restarted nor left half-finished.

// File: rtl/sar_rdout_pkg.sv
package sar_rdout_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_READ,
    ST_DONE
  } seq_st_e;

  // Output container width for a given result width.
  function automatic int cont_w(input int res_w);
    return (res_w > 16) ? 32 : 16;
  endfunction

  // Default conversion times in nanoseconds.
  function automatic int norm_ns(input int res_w);
    return (res_w > 16) ? 500 : 420;
  endfunction

  function automatic int turbo_ns(input int res_w);
    return (res_w > 16) ? 400 : 320;
  endfunction

  // Nanoseconds to system cycles, rounded up, at least one cycle.
  function automatic int ns_to_cyc(input int t_ns, input int clk_ps);
    int c;
    c = (t_ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
  parameter int N_NORM  = 100,
  parameter int N_TURBO = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic turbo_i,
  input  logic run_i,
  output logic done_o
);
  localparam int N_MAX = (N_NORM > N_TURBO) ? N_NORM : N_TURBO;
  localparam int CW    = $clog2(N_MAX + 1);
  localparam logic [CW-1:0] LD_NORM  = CW'(N_NORM - 1);
  localparam logic [CW-1:0] LD_TURBO = CW'(N_TURBO - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= turbo_i ? LD_TURBO : LD_NORM;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign done_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
  parameter int RES_W     = 18,
  parameter int SCLK_HALF = 2,
  parameter bit CPOL      = 1'b0,
  parameter bit CPHA      = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic sclk_o,
  output logic sample_o,
  output logic last_o
);
  localparam int DW = $clog2(SCLK_HALF + 1);
  localparam int NE = 2 * RES_W;
  localparam int EW = $clog2(NE + 1);

  logic [DW-1:0] div_q;
  logic [EW-1:0] edg_q;
  logic          lvl_q;
  logic          tick_w;

  assign tick_w = en_i && (div_q == DW'(SCLK_HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      div_q <= '0;
      edg_q <= '0;
      lvl_q <= CPOL;
    end else if (tick_w) begin
      div_q <= '0;
      edg_q <= edg_q + EW'(1);
      lvl_q <= ~lvl_q;
    end else begin
      div_q <= div_q + DW'(1);
    end
  end

  // Even transition index = leading edge, odd = trailing edge.
  assign sample_o = tick_w && (edg_q[0] == CPHA);
  assign last_o   = tick_w && (edg_q == EW'(NE - 1));
  assign sclk_o   = lvl_q;

endmodule

// File: rtl/sar_shift_rx.sv
module sar_shift_rx #(
  parameter int RES_W      = 18,
  parameter int OUT_W      = 32,
  parameter bit SIGNED_RES = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [OUT_W-1:0] word_o
);
  logic [RES_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (shift_i) begin
      sh_q <= {sh_q[RES_W-2:0], bit_i};
    end
  end

  generate
    if (OUT_W == RES_W) begin : g_exact
      assign word_o = sh_q;
    end else if (SIGNED_RES) begin : g_sext
      assign word_o = {{(OUT_W - RES_W){sh_q[RES_W-1]}}, sh_q};
    end else begin : g_zext
      assign word_o = {{(OUT_W - RES_W){1'b0}}, sh_q};
    end
  endgenerate

endmodule

// File: rtl/sar_rdout_seq.sv
module sar_rdout_seq #(
  parameter int RES_W       = 18,
  parameter bit SIGNED_RES  = 1'b1,
  parameter int CLK_PS      = 5000,
  parameter int T_NORM_NS   = sar_rdout_pkg::norm_ns(RES_W),
  parameter int T_TURBO_NS  = sar_rdout_pkg::turbo_ns(RES_W),
  parameter bit FORCE_TURBO = 1'b0,
  parameter int SCLK_HALF   = 2,
  parameter bit CPOL        = 1'b0,
  parameter bit CPHA        = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic turbo_i,
  output logic busy_o,
  output logic cnv_o,
  output logic cs_n_o,
  output logic sclk_o,
  input  logic sdo_i,
  output logic [sar_rdout_pkg::cont_w(RES_W)-1:0] data_o,
  output logic valid_o
);
  import sar_rdout_pkg::*;

  localparam int OUT_W   = cont_w(RES_W);
  localparam int N_NORM  = ns_to_cyc(T_NORM_NS, CLK_PS);
  localparam int N_TURBO = ns_to_cyc(T_TURBO_NS, CLK_PS);

  seq_st_e          st_q;
  logic             valid_q;
  logic [OUT_W-1:0] data_q;

  // Named internal events
  logic             accept_w;
  logic             conv_done_w;
  logic             bit_take_w;
  logic             last_edge_w;
  logic             in_read_w;
  logic [OUT_W-1:0] word_w;

  assign accept_w  = (st_q == ST_IDLE) && start_i;
  assign in_read_w = (st_q == ST_READ);

  sar_conv_timer #(
    .N_NORM (N_NORM),
    .N_TURBO(N_TURBO)
  ) i_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept_w),
    .turbo_i(turbo_i | FORCE_TURBO),
    .run_i  (st_q == ST_CONV),
    .done_o (conv_done_w)
  );

  sar_sclk_gen #(
    .RES_W    (RES_W),
    .SCLK_HALF(SCLK_HALF),
    .CPOL     (CPOL),
    .CPHA     (CPHA)
  ) i_sclk (
    .clk     (clk),
    .rst     (rst),
    .en_i    (in_read_w),
    .sclk_o  (sclk_o),
    .sample_o(bit_take_w),
    .last_o  (last_edge_w)
  );

  sar_shift_rx #(
    .RES_W     (RES_W),
    .OUT_W     (OUT_W),
    .SIGNED_RES(SIGNED_RES)
  ) i_shift (
    .clk    (clk),
    .rst    (rst),
    .shift_i(bit_take_w),
    .bit_i  (sdo_i),
    .word_o (word_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= (st_q == ST_DONE);
      if (st_q == ST_DONE) data_q <= word_w;
      unique case (st_q)
        ST_IDLE: if (start_i)     st_q <= ST_CONV;
        ST_CONV: if (conv_done_w) st_q <= ST_READ;
        ST_READ: if (last_edge_w) st_q <= ST_DONE;
        ST_DONE:                  st_q <= ST_IDLE;
        default:                  st_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_o   = (st_q == ST_CONV) || (st_q == ST_READ);
  assign cs_n_o  = !in_read_w;
  assign busy_o  = (st_q != ST_IDLE);
  assign data_o  = data_q;
  assign valid_o = valid_q;

  AST_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cnv_o && cs_n_o && !busy_o && !valid_o)); // R1
  AST_CNV_COVERS_CS: assert property (@(posedge clk) disable iff (rst)
    !cs_n_o |-> cnv_o); // R2
  AST_CS_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> $past(conv_done_w)); // R3
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> (sclk_o == CPOL)); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> !$rose(cnv_o)); // R9

endmodule

// File: tb/test_sar_rdout_seq.sv
`timescale 1ns/1ps

module sar_adc_model #(
  parameter int RES_W = 18,
  parameter int OUT_W = 32,
  parameter bit CPOL  = 1'b0,
  parameter bit CPHA  = 1'b0
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             cnv,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             valid,
  input  logic [OUT_W-1:0] data,
  input  logic [RES_W-1:0] word,
  output logic             sdo,
  output int               n_cnv,
  output int               n_pre,
  output int               n_edge,
  output int               n_valid,
  output logic [OUT_W-1:0] cap
);
  logic prv_sclk = CPOL;
  logic prv_cs   = 1'b1;
  bit   cs_seen  = 1'b0;
  int   nxt      = RES_W - 1;
  bit   lead;

  initial begin
    sdo = 1'b0; n_cnv = 0; n_pre = 0; n_edge = 0; n_valid = 0; cap = '0;
  end

  always @(negedge clk) begin
    if (clr) begin
      n_cnv = 0; n_pre = 0; n_edge = 0; n_valid = 0; cs_seen = 1'b0;
    end else begin
      if (cnv) n_cnv++;
      if (cnv && cs_n && !cs_seen) n_pre++;
      if (!cs_n) cs_seen = 1'b1;
      if (valid) begin n_valid++; cap = data; end
      if (sclk != prv_sclk) n_edge++;
    end
    if (cs_n) begin
      nxt = RES_W - 1;
      sdo = 1'b0;
    end else begin
      if (prv_cs && !CPHA) begin sdo = word[nxt]; nxt--; end
      if (sclk != prv_sclk) begin
        lead = (prv_sclk == CPOL);
        if ((CPHA == lead) && nxt >= 0) begin sdo = word[nxt]; nxt--; end
      end
    end
    prv_sclk = sclk;
    prv_cs   = cs_n;
  end
endmodule

module test_sar_rdout_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic start_a = 1'b0, turbo_a = 1'b0, start_b = 1'b0, turbo_b = 1'b0;
  logic busy_a, cnv_a, cs_n_a, sclk_a, sdo_a, valid_a;
  logic busy_b, cnv_b, cs_n_b, sclk_b, sdo_b, valid_b;
  logic [31:0] data_a, cap_a;
  logic [15:0] data_b, cap_b;
  logic [17:0] word_a = '0;
  logic [13:0] word_b = '0;
  int n_cnv_a, n_pre_a, n_edge_a, n_val_a;
  int n_cnv_b, n_pre_b, n_edge_b, n_val_b;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sar_rdout_seq i_sar_rdout_seq (
    .clk(clk), .rst(rst), .start_i(start_a), .turbo_i(turbo_a),
    .busy_o(busy_a), .cnv_o(cnv_a), .cs_n_o(cs_n_a), .sclk_o(sclk_a),
    .sdo_i(sdo_a), .data_o(data_a), .valid_o(valid_a)
  );

  sar_rdout_seq #(
    .RES_W(14), .SIGNED_RES(1'b0), .FORCE_TURBO(1'b1),
    .SCLK_HALF(1), .CPOL(1'b1), .CPHA(1'b1)
  ) i_sar_rdout_seq_u14 (
    .clk(clk), .rst(rst), .start_i(start_b), .turbo_i(turbo_b),
    .busy_o(busy_b), .cnv_o(cnv_b), .cs_n_o(cs_n_b), .sclk_o(sclk_b),
    .sdo_i(sdo_b), .data_o(data_b), .valid_o(valid_b)
  );

  sar_adc_model #(.RES_W(18), .OUT_W(32), .CPOL(1'b0), .CPHA(1'b0)) i_model_a (
    .clk(clk), .clr(clr), .cnv(cnv_a), .cs_n(cs_n_a), .sclk(sclk_a),
    .valid(valid_a), .data(data_a), .word(word_a), .sdo(sdo_a),
    .n_cnv(n_cnv_a), .n_pre(n_pre_a), .n_edge(n_edge_a), .n_valid(n_val_a), .cap(cap_a)
  );

  sar_adc_model #(.RES_W(14), .OUT_W(16), .CPOL(1'b1), .CPHA(1'b1)) i_model_b (
    .clk(clk), .clr(clr), .cnv(cnv_b), .cs_n(cs_n_b), .sclk(sclk_b),
    .valid(valid_b), .data(data_b), .word(word_b), .sdo(sdo_b),
    .n_cnv(n_cnv_b), .n_pre(n_pre_b), .n_edge(n_edge_b), .n_valid(n_val_b), .cap(cap_b)
  );

  function automatic int cyc(input int t_ns);
    return (t_ns * 1000 + 4999) / 5000;
  endfunction

  function automatic logic [31:0] ext_a(input logic [17:0] w);
    return {{14{w[17]}}, w};
  endfunction

  function automatic logic [31:0] ext_b(input logic [13:0] w);
    return {18'b0, w};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xact(input bit b, input logic [17:0] w, input bit t, input bit mid);
    int n_exp, tot_exp, nv;
    logic [31:0] d_exp;
    if (b) begin
      word_b = w[13:0]; turbo_b = t;
      n_exp = cyc(320);
      tot_exp = n_exp + 2 * 14 * 1;
      d_exp = ext_b(w[13:0]);
    end else begin
      word_a = w; turbo_a = t;
      n_exp = cyc(t ? 400 : 500);
      tot_exp = n_exp + 2 * 18 * 2;
      d_exp = ext_a(w);
    end
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    if (b) start_b = 1'b1; else start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0; start_b = 1'b0;
    chk(b ? (busy_b && cnv_b) : (busy_a && cnv_a), "R2 convert and busy rise after start",
        b ? {30'b0, busy_b, cnv_b} : {30'b0, busy_a, cnv_a}, 32'h3);
    if (mid) begin
      repeat (n_exp + 10) @(negedge clk);
      if (b) begin start_b = 1'b1; turbo_b = ~turbo_b; end
      else begin start_a = 1'b1; turbo_a = ~turbo_a; end
      @(negedge clk);
      start_a = 1'b0; start_b = 1'b0;
    end
    for (int i = 0; i < 2000; i++) begin
      nv = b ? n_val_b : n_val_a;
      if (nv != 0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    if (b) begin
      chk(n_val_b == 1, "R8 single valid pulse", n_val_b, 1);
      chk({16'b0, cap_b} == d_exp, "R6 R7 captured result", {16'b0, cap_b}, d_exp);
      chk({16'b0, data_b} == d_exp, "R8 result held", {16'b0, data_b}, d_exp);
      chk(n_cnv_b == tot_exp, "R2 convert high length", n_cnv_b, tot_exp);
      chk(n_pre_b == n_exp, "R3 R4 select idle during forced-turbo wait", n_pre_b, n_exp);
      chk(n_edge_b == 28, "R5 clock transitions", n_edge_b, 28);
      chk(sclk_b == 1'b1 && cs_n_b, "R5 clock idle level", {30'b0, cs_n_b, sclk_b}, 32'h3);
    end else begin
      chk(n_val_a == 1, "R8 single valid pulse", n_val_a, 1);
      chk(cap_a == d_exp, "R6 R7 captured result", cap_a, d_exp);
      chk(data_a == d_exp, "R8 result held", data_a, d_exp);
      chk(n_cnv_a == tot_exp, "R2 convert high length", n_cnv_a, tot_exp);
      chk(n_pre_a == n_exp, "R3 R4 select idle during wait", n_pre_a, n_exp);
      chk(n_edge_a == 36, "R5 clock transitions", n_edge_a, 36);
      chk(sclk_a == 1'b0 && cs_n_a, "R5 clock idle level", {30'b0, cs_n_a, sclk_a}, 32'h2);
    end
    if (mid) begin
      repeat (30) @(negedge clk);
      chk(b ? (n_cnv_b == tot_exp && !busy_b) : (n_cnv_a == tot_exp && !busy_a),
          "R9 start while busy ignored", b ? n_cnv_b : n_cnv_a, tot_exp);
      turbo_a = 1'b0; turbo_b = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!cnv_a && cs_n_a && !sclk_a && !busy_a && !valid_a, "R1 reset state A",
        {27'b0, cnv_a, cs_n_a, sclk_a, busy_a, valid_a}, 32'h8);
    chk(!cnv_b && cs_n_b && sclk_b && !busy_b && !valid_b, "R1 reset state B",
        {27'b0, cnv_b, cs_n_b, sclk_b, busy_b, valid_b}, 32'hC);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // Directed corners, 18-bit signed (R7 sign extension, R6 bit order)
    xact(1'b0, 18'h00000, 1'b0, 1'b0);
    xact(1'b0, 18'h3FFFF, 1'b0, 1'b0);
    xact(1'b0, 18'h20000, 1'b1, 1'b0);
    xact(1'b0, 18'h1FFFF, 1'b1, 1'b0);
    xact(1'b0, 18'h00001, 1'b0, 1'b0);
    // Random words and turbo (R4)
    for (int k = 0; k < 8; k++) xact(1'b0, 18'($urandom), 1'($urandom), 1'b0);
    // R9 repeated start during a read
    xact(1'b0, 18'h2A5C3, 1'b0, 1'b1);

    // R10 reset in the middle of a read
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    word_a = 18'h15A5A;
    start_a = 1'b1;
    @(negedge clk) start_a = 1'b0;
    repeat (130) @(negedge clk);
    chk(!cs_n_a, "R10 read in progress before reset", {31'b0, cs_n_a}, 0);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(!cnv_a && cs_n_a && !sclk_a && !busy_a, "R10 idle after reset",
        {28'b0, cnv_a, cs_n_a, sclk_a, busy_a}, 32'h4);
    repeat (200) @(negedge clk);
    chk(n_val_a == 0, "R10 no valid after reset", n_val_a, 0);
    xact(1'b0, 18'h0F0F0, 1'b0, 1'b0);

    // 14-bit unsigned, idle-high clock, trailing capture, forced turbo (R4)
    xact(1'b1, 18'h03FFF, 1'b0, 1'b0);
    xact(1'b1, 18'h02000, 1'b0, 1'b0);
    xact(1'b1, 18'h00001, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) xact(1'b1, 18'($urandom), 1'b0, 1'b0);
    xact(1'b1, 18'h01234, 1'b0, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule